// File: doc/BRIEF.md
# Dual-Pattern Overlapping Serial Detector

This block watches a serial bit stream and takes one bit on every rising clock edge. It raises its detect output in any cycle where the newest four bits, oldest first, spell either 1011 or 1100. The newest four bits include the bit present on the input in that cycle.

A single state machine tracks both patterns. The state is the longest recent suffix that could still grow into either pattern. Matches may therefore overlap, both within one pattern and from one pattern into the other. The output is Mealy: it comes combinationally from the state and the present input bit, so a match is flagged in the same cycle as its last bit. A synchronous reset clears all partial history.

Top module: `sqd_dual_detect`

## Requirements
- R1: `det_o` is 1 in any cycle where the last three bits taken since reset, followed by the present `din_i`, are 1,1,0,0.
- R2: `det_o` is 1 in any cycle where the last three bits taken since reset, followed by the present `din_i`, are 1,0,1,1.
- R3: `det_o` is 0 in every cycle in which neither pattern ends on the present bit.
- R4: Overlapping matches are all reported. Two 1011 matches may share bits (1011011 gives two detections). The tail of a 1011 may begin a 1100 (101100 gives detections on its 4th and 6th bits).
- R5: A detection appears in the same cycle as the final pattern bit. No clock edge lies between the input and the output.
- R6: Reset is synchronous and active-high. While `rst_i` is 1, `det_o` is 0 whatever `din_i` is. After reset the machine holds no partial match.
- R7: Bits taken before a reset never count toward a match. No detection occurs until at least three bits have been taken after reset and the present bit completes a pattern.
- R8: For the stream 1,1,1,1,0,0,0,0,1,0,1,1,0,1,1,0,0 applied after reset, `det_o` is 0,0,0,0,0,1,0,0,0,0,0,1,0,0,1,0,1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one serial bit is taken per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| din_i | input | 1 | Serial data bit |
| det_o | output | 1 | Match flag, combinational from the state and `din_i` |

## Verification
Every result is due in the same cycle as the bit that completes a pattern, with zero clock edges of latency. The bench therefore changes `din_i` on the falling edge and samples `det_o` a short settle time later, before the next rising edge registers the bit. Only after that sample does the reference model shift the bit into its history. The reference is a queue of the bits taken since reset, and the queue is emptied whenever reset is applied. A reset held across a falling edge is checked for a quiet output while `din_i` is 1.

// File: rtl/sqd_pkg.sv
package sqd_pkg;
  // Each state names the longest recent suffix that is a prefix of 1100 or 1011.
  typedef enum logic [2:0] {
    ST_NONE = 3'd0,
    ST_P1   = 3'd1,
    ST_P11  = 3'd2,
    ST_P110 = 3'd3,
    ST_P10  = 3'd4,
    ST_P101 = 3'd5
  } sqd_state_e;

  localparam int SQD_PAT_LEN = 4;
  localparam logic [SQD_PAT_LEN-1:0] SQD_PAT_A = 4'b1100;
  localparam logic [SQD_PAT_LEN-1:0] SQD_PAT_B = 4'b1011;
endpackage

// File: rtl/sqd_step.sv
module sqd_step
  import sqd_pkg::*;
(
  input  sqd_state_e cur_i,
  input  logic       bit_i,
  output sqd_state_e nxt_o,
  output logic       hit_o
);
  always_comb begin
    nxt_o = ST_NONE;
    hit_o = 1'b0;
    unique case (cur_i)
      ST_NONE: nxt_o = bit_i ? ST_P1 : ST_NONE;
      ST_P1:   nxt_o = bit_i ? ST_P11 : ST_P10;
      ST_P11:  nxt_o = bit_i ? ST_P11 : ST_P110;
      ST_P110: begin
        if (bit_i) nxt_o = ST_P101;
        else begin
          nxt_o = ST_NONE;
          hit_o = 1'b1;
        end
      end
      ST_P10:  nxt_o = bit_i ? ST_P101 : ST_NONE;
      ST_P101: begin
        if (bit_i) begin
          nxt_o = ST_P11;
          hit_o = 1'b1;
        end else nxt_o = ST_P10;
      end
      default: begin
        nxt_o = ST_NONE;
        hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sqd_state_reg.sv
module sqd_state_reg
  import sqd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  sqd_state_e nxt_i,
  output sqd_state_e cur_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) cur_o <= ST_NONE;
    else       cur_o <= nxt_i;
  end

  p_idle_after_reset_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (cur_o == ST_NONE));

  p_legal_state_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_o inside {ST_NONE, ST_P1, ST_P11, ST_P110, ST_P10, ST_P101}));
endmodule

// File: rtl/sqd_dual_detect.sv
module sqd_dual_detect
  import sqd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic din_i,
  output logic det_o
);
  localparam int HistW = SQD_PAT_LEN - 1;

  sqd_state_e cur_q;
  sqd_state_e nxt_d;
  logic       hit_d;

  sqd_step u_step (
    .cur_i (cur_q),
    .bit_i (din_i),
    .nxt_o (nxt_d),
    .hit_o (hit_d)
  );

  sqd_state_reg u_state (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .nxt_i (nxt_d),
    .cur_o (cur_q)
  );

  assign det_o = hit_d & ~rst_i;

  // Shadow history of the bits taken since reset; it feeds the assertions only.
  logic [HistW-1:0] chk_hist_q;
  logic [1:0]       chk_fill_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chk_hist_q <= '0;
      chk_fill_q <= '0;
    end else begin
      chk_hist_q <= {chk_hist_q[HistW-2:0], din_i};
      if (chk_fill_q != 2'd3) chk_fill_q <= chk_fill_q + 2'd1;
    end
  end

  always_comb begin
    if (rst_i) p_quiet_in_reset_r6: assert (!det_o);
  end

  p_warmup_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (chk_fill_q != 2'd3) |-> !det_o);

  p_hit_pat_a_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    ((chk_fill_q == 2'd3) && ({chk_hist_q, din_i} == SQD_PAT_A)) |-> det_o);

  p_hit_pat_b_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    ((chk_fill_q == 2'd3) && ({chk_hist_q, din_i} == SQD_PAT_B)) |-> det_o);

  p_no_false_hit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    det_o |-> ((chk_fill_q == 2'd3) &&
               (({chk_hist_q, din_i} == SQD_PAT_A) || ({chk_hist_q, din_i} == SQD_PAT_B))));
endmodule

// File: tb/sqd_dual_detect_bench.sv
`timescale 1ns/1ps
module sqd_dual_detect_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic det;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  bit hist[$];

  always #4 clk = ~clk;

  sqd_dual_detect u_sqd_dual_detect (
    .clk_i (clk),
    .rst_i (rst),
    .din_i (din),
    .det_o (det)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s t=%0t det=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // Present one bit, compare the same-cycle output with the model, then commit.
  task automatic send(input bit b, input string phase);
    logic exp;
    logic [3:0] w;
    string tag;
    @(negedge clk);
    din = b;
    #2;
    exp = 1'b0;
    w = 4'b0;
    if (hist.size() >= 3) begin
      w = {hist[hist.size()-3], hist[hist.size()-2], hist[hist.size()-1], b};
      exp = (w == 4'b1100) || (w == 4'b1011);
    end
    if (phase != "") tag = phase;
    else if (exp && w == 4'b1100) tag = "R1";
    else if (exp) tag = "R2";
    else if (hist.size() < 3) tag = "R7";
    else tag = "R3";
    check(det, exp, tag);
    hist.push_back(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b1;
    #2;
    check(det, 1'b0, "R6 quiet during reset");
    @(negedge clk);
    din = 1'b0;
    #2;
    check(det, 1'b0, "R6 quiet during reset");
    rst = 1'b0;
    hist.delete();
  endtask

  task automatic send_vec(input logic [31:0] v, input int n, input string phase);
    for (int i = n - 1; i >= 0; i--) send(v[i], phase);
  endtask

  initial begin
    do_reset();
    send_vec(32'b11110000101101100, 17, "R8");
    do_reset();
    send_vec(32'b1011011, 7, "R4 back-to-back 1011");
    send_vec(32'b00101100, 8, "R4 1011 into 1100");
    send_vec(32'b110011001100, 12, "R4 repeated 1100");
    send_vec(32'b11011, 5, "R5");
    do_reset();
    send_vec(32'b101, 3, "");
    do_reset();
    send(1'b1, "R7 history cleared");
    send(1'b0, "R7 history cleared");
    send(1'b1, "R7 history cleared");
    send(1'b1, "R7 first match");
    for (int i = 0; i < 3000; i++) send(($urandom % 5) != 0, "");
    do_reset();
    for (int i = 0; i < 3000; i++) send($urandom % 2, "");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule